// File: doc/BRIEF.md
# Bridge Memory Window Forwarding Decoder

This block sits beside the address path of a two-sided bus bridge and decides, for each memory transaction, whether the bridge claims it and in which direction it goes. The primary side is the upstream bus and the secondary side is the downstream bus. Two address windows are held in configuration registers. One is a non-prefetchable window for memory-mapped I/O. The other is a prefetchable window for memory that is safe to read ahead. Both are coded at 1 MB granularity.

A transaction on the primary side that lands inside either window is sent downstream. A transaction on the secondary side that lands outside both windows is sent upstream, unless an external VGA-hit input marks it as belonging to the legacy display range. For each forwarded read the block also says whether the bridge may prefetch or must stop after one data phase.

Software programs the windows through a 16-bit configuration port with byte enables. Two enable inputs gate the two directions: a memory-enable for downstream and a master-enable for upstream. Each decision appears on registered outputs one clock after the transaction strobe.

Top module: `memwin_fwd_decoder`

## Requirements
- R1: After reset all four window registers read 0000h. Both windows then cover addresses 00000000h to 000FFFFFh, so a primary read at 000FFFFCh is forwarded and a primary read at 00100000h is not. After reset, all decision outputs are 0.
- R2: Register offsets: 20h is the I/O window base, 22h the I/O window limit, 24h the prefetch window base and 26h the prefetch window limit. `cfg_be[0]` enables the write of data bits [7:0] and `cfg_be[1]` enables the write of bits [15:8]. Register bits [3:0] always read 0. A write to any other offset changes nothing, and a read of any other offset returns 0000h.
- R3: Register bits [15:4] give address bits [31:20]. The base takes implied low bits 00000h and the limit takes implied low bits FFFFFh. Both ends of the window are inclusive, so a window can cover the whole 4 GB space.
- R4: A window whose base field is greater than its limit field matches no address. A window whose base field equals its limit field covers exactly one 1 MB block.
- R5: A transaction with `txn_side`=0 (primary) is forwarded downstream (`fwd_down`=1) only when all of these hold: it is a memory command, its address hits either window, and `mem_en` is 1.
- R6: A transaction with `txn_side`=1 (secondary) is forwarded upstream (`fwd_up`=1) only when all of these hold: it is a memory command, its address hits neither window, `vga_hit` is 0, and `master_en` is 1.
- R7: A secondary-side transaction never sets `fwd_down`. A primary-side transaction never sets `fwd_up`. In particular, a secondary-side transaction inside a window is ignored.
- R8: The memory command codes are 0110b (read), 0111b (write), 1100b (read multiple), 1110b (read line) and 1111b (write and invalidate). Any other code is never forwarded, and all its flags stay 0.
- R9: A downstream read that hits the prefetchable window sets `pf_ok`=1 and `single_xfer`=0 for all three read codes. This rule wins when an address hits both windows.
- R10: Any other forwarded read, whether it hits the I/O window or goes upstream, sets `pf_ok` for read line and read multiple. A plain read sets `single_xfer`=1 instead.
- R11: Forwarded writes leave `pf_ok` and `single_xfer` at 0. A transaction that is not forwarded leaves both flags at 0.
- R12: The outputs are registered. `dec_valid` and the decision outputs reflect the inputs present at the clock edge where `txn_valid` was 1, and they appear one cycle later. In a cycle after an edge without `txn_valid`, all of them are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_be | input | 2 | Byte enables for the write |
| cfg_wdata | input | 16 | Write data |
| cfg_rdata | output | 16 | Read data for `cfg_addr` (combinational) |
| mem_en | input | 1 | Allows downstream forwarding |
| master_en | input | 1 | Allows upstream forwarding |
| txn_valid | input | 1 | Transaction strobe |
| txn_addr | input | 32 | Transaction address |
| txn_cmd | input | 4 | Bus command code |
| txn_side | input | 1 | 0 = primary side, 1 = secondary side |
| vga_hit | input | 1 | External legacy-display range hit |
| dec_valid | output | 1 | Decision valid |
| fwd_down | output | 1 | Forward primary to secondary |
| fwd_up | output | 1 | Forward secondary to primary |
| pf_ok | output | 1 | Prefetch allowed |
| single_xfer | output | 1 | Limit the transfer to one data phase |

## Verification
The bench probes the inclusive window edges at xxx00000h and xxxFFFFFh. A comparator that is off by one, or one that ignores the implied low bits, would forward one block too few or too many there. It programs a base above its limit and a base equal to its limit; a design that treats the window as wrapping around, or that rejects the equal case, fails those checks. It also covers overlap of both windows right after reset, where a design without prefetch-window priority would wrongly flag a single transfer. Other cases are a VGA hit seen from each side, non-memory codes, single-byte register writes and unmapped offsets. These catch a decoder that leaks forwarding to the wrong side or corrupts the other byte of a register.

// File: rtl/memwin_pkg.sv
package memwin_pkg;

   // bus command codes that name memory transactions
   localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
   localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
   localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
   localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
   localparam logic [3:0] CMD_MEM_WR_INV  = 4'b1111;

   typedef enum logic {
      SIDE_PRI = 1'b0,
      SIDE_SEC = 1'b1
   } side_e;

   typedef struct packed {
      logic is_mem;
      logic is_read;
      logic rd_burst;
   } cmd_class_t;

   typedef struct packed {
      logic down;
      logic up;
      logic pf;
      logic single;
   } fwd_dec_t;

endpackage

// File: rtl/memwin_cfg_regs.sv
module memwin_cfg_regs #(
   parameter int NUM_WIN   = 2,
   parameter int REG_W     = 16,
   parameter int UPPER_W   = 12,
   parameter int CFG_AW    = 8,
   parameter int FIRST_OFS = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [REG_W/8-1:0]   cfg_be,
   input  logic [REG_W-1:0]     cfg_wdata,
   output logic [REG_W-1:0]     cfg_rdata,
   output logic [UPPER_W-1:0]   base_hi [NUM_WIN],
   output logic [UPPER_W-1:0]   lim_hi  [NUM_WIN]
);
   localparam int NREG  = 2 * NUM_WIN;
   localparam int LANES = REG_W / 8;
   localparam int LOW_W = REG_W - UPPER_W;

   if (REG_W % 8 != 0) begin : g_bad_reg_w
      $error("memwin_cfg_regs: REG_W must be a whole number of bytes");
   end
   if (LOW_W < 1) begin : g_bad_upper_w
      $error("memwin_cfg_regs: UPPER_W must leave at least one fixed low bit");
   end

   logic [NREG*UPPER_W-1:0] field_flat;
   logic [NREG-1:0]         ofs_sel;

   // register r sits at FIRST_OFS + 2*r: even r is a base, odd r a limit
   for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam int OFS = FIRST_OFS + 2 * r;
      logic [UPPER_W-1:0] fld_q;
      logic [REG_W-1:0]   cur_val;
      logic [REG_W-1:0]   merged;

      assign ofs_sel[r] = (cfg_addr == CFG_AW'(OFS));
      assign cur_val    = {fld_q, {LOW_W{1'b0}}};

      always_comb begin
         merged = cur_val;
         for (int b = 0; b < LANES; b++) begin
            if (cfg_be[b]) merged[b*8 +: 8] = cfg_wdata[b*8 +: 8];
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)                    fld_q <= '0;
         else if (cfg_wr && ofs_sel[r]) fld_q <= merged[REG_W-1:LOW_W];
      end

      assign field_flat[r*UPPER_W +: UPPER_W] = fld_q;
   end

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win_out
      assign base_hi[w] = field_flat[(2*w)*UPPER_W   +: UPPER_W];
      assign lim_hi[w]  = field_flat[(2*w+1)*UPPER_W +: UPPER_W];
   end

   always_comb begin
      cfg_rdata = '0;
      for (int r = 0; r < NREG; r++) begin
         if (ofs_sel[r]) cfg_rdata = {field_flat[r*UPPER_W +: UPPER_W], {LOW_W{1'b0}}};
      end
   end

endmodule

// File: rtl/memwin_range_match.sv
module memwin_range_match #(
   parameter int UPPER_W = 12
) (
   input  logic [UPPER_W-1:0] addr_hi,
   input  logic [UPPER_W-1:0] base_hi,
   input  logic [UPPER_W-1:0] lim_hi,
   output logic               hit
);
   // only the upper address bits are compared: the implied low bits make
   // the base inclusive from xxx00000h and the limit inclusive to xxxFFFFFh;
   // base above limit leaves no value satisfying both bounds
   logic above_base;
   logic below_lim;

   assign above_base = (addr_hi >= base_hi);
   assign below_lim  = (addr_hi <= lim_hi);
   assign hit        = above_base && below_lim;

endmodule

// File: rtl/memwin_cmd_classify.sv
module memwin_cmd_classify
   import memwin_pkg::*;
(
   input  logic [3:0]  cmd,
   output cmd_class_t  cls
);
   always_comb begin
      cls = '0;
      unique case (cmd)
         CMD_MEM_RD:      begin cls.is_mem = 1'b1; cls.is_read = 1'b1; end
         CMD_MEM_RD_MULT,
         CMD_MEM_RD_LINE: begin cls.is_mem = 1'b1; cls.is_read = 1'b1; cls.rd_burst = 1'b1; end
         CMD_MEM_WR,
         CMD_MEM_WR_INV:  cls.is_mem = 1'b1;
         default:         cls = '0;
      endcase
   end

endmodule

// File: rtl/memwin_fwd_decoder.sv
module memwin_fwd_decoder
   import memwin_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int GRAN_BITS = 20,
   parameter int REG_W     = 16,
   parameter int CFG_AW    = 8,
   parameter int FIRST_OFS = 32,
   parameter int NUM_WIN   = 2,
   parameter int PF_WIN    = 1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_wr,
   input  logic [CFG_AW-1:0]    cfg_addr,
   input  logic [REG_W/8-1:0]   cfg_be,
   input  logic [REG_W-1:0]     cfg_wdata,
   output logic [REG_W-1:0]     cfg_rdata,
   input  logic                 mem_en,
   input  logic                 master_en,
   input  logic                 txn_valid,
   input  logic [ADDR_W-1:0]    txn_addr,
   input  logic [3:0]           txn_cmd,
   input  logic                 txn_side,
   input  logic                 vga_hit,
   output logic                 dec_valid,
   output logic                 fwd_down,
   output logic                 fwd_up,
   output logic                 pf_ok,
   output logic                 single_xfer
);
   localparam int UPPER_W = ADDR_W - GRAN_BITS;

   if (GRAN_BITS < 1 || GRAN_BITS >= ADDR_W) begin : g_bad_gran
      $error("memwin_fwd_decoder: GRAN_BITS must lie inside the address");
   end
   if (PF_WIN < 0 || PF_WIN >= NUM_WIN) begin : g_bad_pf_win
      $error("memwin_fwd_decoder: PF_WIN must name an existing window");
   end
   if (UPPER_W >= REG_W) begin : g_bad_widths
      $error("memwin_fwd_decoder: upper address field does not fit a register");
   end

   logic [UPPER_W-1:0] base_hi [NUM_WIN];
   logic [UPPER_W-1:0] lim_hi  [NUM_WIN];
   logic [UPPER_W-1:0] addr_hi;
   logic [NUM_WIN-1:0] win_hit;
   cmd_class_t         cls;
   fwd_dec_t           dec_d;
   fwd_dec_t           dec_q;
   logic               valid_q;

   memwin_cfg_regs #(
      .NUM_WIN   (NUM_WIN),
      .REG_W     (REG_W),
      .UPPER_W   (UPPER_W),
      .CFG_AW    (CFG_AW),
      .FIRST_OFS (FIRST_OFS)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .cfg_wr    (cfg_wr),
      .cfg_addr  (cfg_addr),
      .cfg_be    (cfg_be),
      .cfg_wdata (cfg_wdata),
      .cfg_rdata (cfg_rdata),
      .base_hi   (base_hi),
      .lim_hi    (lim_hi)
   );

   assign addr_hi = txn_addr[ADDR_W-1:GRAN_BITS];

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      memwin_range_match #(
         .UPPER_W (UPPER_W)
      ) u_match (
         .addr_hi (addr_hi),
         .base_hi (base_hi[w]),
         .lim_hi  (lim_hi[w]),
         .hit     (win_hit[w])
      );
   end

   memwin_cmd_classify u_cls (
      .cmd (txn_cmd),
      .cls (cls)
   );

   logic hit_any;
   logic hit_pf;
   logic from_pri;
   logic fwd_any;

   assign hit_any  = |win_hit;
   assign hit_pf   = win_hit[PF_WIN];
   assign from_pri = (side_e'(txn_side) == SIDE_PRI);

   always_comb begin
      dec_d      = '0;
      dec_d.down = from_pri  && cls.is_mem && hit_any && mem_en;
      dec_d.up   = !from_pri && cls.is_mem && !hit_any && !vga_hit && master_en;
      fwd_any    = dec_d.down || dec_d.up;
      // prefetchable window wins over the I/O window when both hit
      dec_d.pf     = fwd_any && cls.is_read && ((dec_d.down && hit_pf) || cls.rd_burst);
      dec_d.single = fwd_any && cls.is_read && !dec_d.pf;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         dec_q   <= '0;
      end else begin
         valid_q <= txn_valid;
         dec_q   <= txn_valid ? dec_d : '0;
      end
   end

   assign dec_valid   = valid_q;
   assign fwd_down    = dec_q.down;
   assign fwd_up      = dec_q.up;
   assign pf_ok       = dec_q.pf;
   assign single_xfer = dec_q.single;

endmodule

// File: rtl/memwin_fwd_checker.sv
module memwin_fwd_checker
   import memwin_pkg::*;
#(
   parameter int REG_W   = 16,
   parameter int UPPER_W = 12
) (
   input logic             clk,
   input logic             rst_n,
   input logic [REG_W-1:0] cfg_rdata,
   input logic             mem_en,
   input logic             master_en,
   input logic             txn_valid,
   input logic [3:0]       txn_cmd,
   input logic             txn_side,
   input logic             vga_hit,
   input logic             dec_valid,
   input logic             fwd_down,
   input logic             fwd_up,
   input logic             pf_ok,
   input logic             single_xfer
);
   localparam int LOW_W = REG_W - UPPER_W;

   logic cmd_is_mem;
   logic cmd_is_wr;
   assign cmd_is_wr  = (txn_cmd == CMD_MEM_WR) || (txn_cmd == CMD_MEM_WR_INV);
   assign cmd_is_mem = cmd_is_wr || (txn_cmd == CMD_MEM_RD) ||
                       (txn_cmd == CMD_MEM_RD_MULT) || (txn_cmd == CMD_MEM_RD_LINE);

   AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_rdata[LOW_W-1:0] == '0); // R2
   AST_STROBE_GIVES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid |=> dec_valid); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !txn_valid |=> !dec_valid && !fwd_down && !fwd_up && !pf_ok && !single_xfer); // R12
   AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_down && fwd_up)); // R7
   AST_SEC_NEVER_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_side |=> !fwd_down); // R7
   AST_PRI_NEVER_UP: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !txn_side |=> !fwd_up); // R7
   AST_MEMEN_GATES_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !mem_en |=> !fwd_down); // R5
   AST_MASTER_GATES_UP: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !master_en |=> !fwd_up); // R6
   AST_VGA_BLOCKS_UP: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_side && vga_hit |=> !fwd_up); // R6
   AST_NONMEM_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && !cmd_is_mem |=> !fwd_down && !fwd_up && !pf_ok && !single_xfer); // R8
   AST_WRITE_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && cmd_is_wr |=> !pf_ok && !single_xfer); // R11
   AST_UP_PLAIN_READ_NO_PF: assert property (@(posedge clk) disable iff (!rst_n)
      txn_valid && txn_side && txn_cmd == CMD_MEM_RD |=> !pf_ok); // R10
   AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(pf_ok && single_xfer)); // R10
   AST_FLAGS_NEED_FWD: assert property (@(posedge clk) disable iff (!rst_n)
      (pf_ok || single_xfer) |-> (fwd_down || fwd_up)); // R11

endmodule

bind memwin_fwd_decoder memwin_fwd_checker #(
   .REG_W   (REG_W),
   .UPPER_W (ADDR_W - GRAN_BITS)
) u_chk (.*);

// File: tb/memwin_fwd_decoder_bench.sv
module memwin_fwd_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_wr = 1'b0;
   logic [7:0]  cfg_addr = '0;
   logic [1:0]  cfg_be = '0;
   logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata;
   logic        mem_en = 1'b1;
   logic        master_en = 1'b1;
   logic        txn_valid = 1'b0;
   logic [31:0] txn_addr = '0;
   logic [3:0]  txn_cmd = '0;
   logic        txn_side = 1'b0;
   logic        vga_hit = 1'b0;
   logic        dec_valid, fwd_down, fwd_up, pf_ok, single_xfer;

   int n_run = 0;
   int n_fail = 0;

   always #4 clk = ~clk; // 125 MHz

   memwin_fwd_decoder u_memwin_fwd_decoder (.*);

   // {side, vga, cmd, addr, exp {down, up, pf, single}}
   // windows: I/O 10000000h..1FFFFFFFh, prefetch 40000000h..4FFFFFFFh
   localparam int NVEC = 16;
   localparam logic [41:0] VECS [NVEC] = '{
      {1'b0, 1'b0, 4'h6, 32'h1000_0000, 4'b1001}, // R3 low edge, R10 plain read single
      {1'b0, 1'b0, 4'hE, 32'h1FFF_FFFC, 4'b1010}, // R3 top edge, R10 read line
      {1'b0, 1'b0, 4'hC, 32'h1234_5678, 4'b1010}, // R10 read multiple
      {1'b0, 1'b0, 4'h7, 32'h2000_0000, 4'b0000}, // R5 just above window
      {1'b0, 1'b0, 4'h6, 32'h0FFF_FFFC, 4'b0000}, // R5 just below window
      {1'b0, 1'b0, 4'h6, 32'h4000_0000, 4'b1010}, // R9 plain read prefetches
      {1'b0, 1'b0, 4'hF, 32'h4FFF_FFFF, 4'b1000}, // R11 write no flags
      {1'b1, 1'b0, 4'h6, 32'h1000_0000, 4'b0000}, // R7 secondary inside I/O window
      {1'b1, 1'b0, 4'h6, 32'h4400_0000, 4'b0000}, // R6 secondary inside prefetch window
      {1'b1, 1'b0, 4'h6, 32'h8000_0000, 4'b0101}, // R6 upstream plain read, R10
      {1'b1, 1'b0, 4'hE, 32'h8000_0000, 4'b0110}, // R10 upstream read line
      {1'b1, 1'b1, 4'h6, 32'h8000_0000, 4'b0000}, // R6 vga hit blocks
      {1'b1, 1'b0, 4'h7, 32'h0000_0000, 4'b0100}, // R11 upstream write
      {1'b0, 1'b1, 4'h6, 32'h8000_0000, 4'b0000}, // R7 primary outside, vga no effect
      {1'b0, 1'b0, 4'h2, 32'h1000_0000, 4'b0000}, // R8 non-memory code
      {1'b1, 1'b0, 4'hA, 32'h8000_0000, 4'b0000}  // R8 non-memory code
   };

   task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cfg_write(input logic [7:0] ofs, input logic [15:0] data, input logic [1:0] be);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = ofs; cfg_wdata = data; cfg_be = be;
      @(negedge clk);
      cfg_wr = 1'b0; cfg_be = '0;
   endtask

   task automatic cfg_check(input logic [7:0] ofs, input logic [15:0] exp, input string tag);
      @(negedge clk);
      cfg_addr = ofs;
      #1;
      check(tag, cfg_rdata, exp);
   endtask

   task automatic txn(input logic side, input logic vga, input logic [3:0] cmd,
                      input logic [31:0] addr, input logic [3:0] exp, input string tag);
      @(negedge clk);
      txn_valid = 1'b1; txn_side = side; vga_hit = vga; txn_cmd = cmd; txn_addr = addr;
      @(negedge clk);
      txn_valid = 1'b0; txn_addr = 32'hDEAD_BEEF; txn_cmd = 4'h6;
      check({tag, " valid"}, {15'd0, dec_valid}, 16'd1);
      check(tag, {12'd0, fwd_down, fwd_up, pf_ok, single_xfer}, {12'd0, exp});
   endtask

   initial begin
      #(8 * 200000);
      n_fail++;
      $display("FAIL R12 watchdog expired actual=running expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 outputs after reset", {11'd0, dec_valid, fwd_down, fwd_up, pf_ok, single_xfer}, 16'd0);
      cfg_check(8'h20, 16'h0000, "R1 io base reset");
      cfg_check(8'h22, 16'h0000, "R1 io limit reset");
      cfg_check(8'h24, 16'h0000, "R1 pf base reset");
      cfg_check(8'h26, 16'h0000, "R1 pf limit reset");
      txn(1'b0, 1'b0, 4'h6, 32'h000F_FFFC, 4'b1010, "R1 R9 bottom 1MB overlap");
      txn(1'b0, 1'b0, 4'h6, 32'h0010_0000, 4'b0000, "R1 above bottom 1MB");

      // R2 configuration access
      cfg_write(8'h20, 16'h1000, 2'b11);
      cfg_check(8'h20, 16'h1000, "R2 io base write");
      cfg_write(8'h22, 16'h1FFF, 2'b11);
      cfg_check(8'h22, 16'h1FF0, "R2 low bits read zero");
      cfg_write(8'h24, 16'hAB40, 2'b01);
      cfg_check(8'h24, 16'h0040, "R2 low byte only");
      cfg_write(8'h24, 16'h40FF, 2'b10);
      cfg_check(8'h24, 16'h4040, "R2 high byte only");
      cfg_write(8'h24, 16'h4000, 2'b11);
      cfg_write(8'h26, 16'h4FF0, 2'b11);
      cfg_write(8'h28, 16'hFFFF, 2'b11);
      cfg_check(8'h28, 16'h0000, "R2 unmapped offset reads zero");
      cfg_check(8'h20, 16'h1000, "R2 unmapped write left io base");
      cfg_check(8'h22, 16'h1FF0, "R2 unmapped write left io limit");
      cfg_check(8'h24, 16'h4000, "R2 unmapped write left pf base");
      cfg_check(8'h26, 16'h4FF0, "R2 unmapped write left pf limit");

      // table walk (R5..R11)
      for (int i = 0; i < NVEC; i++) begin
         txn(VECS[i][41], VECS[i][40], VECS[i][39:36], VECS[i][35:4], VECS[i][3:0],
             $sformatf("R5/R6/R7/R8/R9/R10/R11 vector %0d", i));
      end

      // R12 quiet after an idle edge
      @(negedge clk);
      check("R12 idle cycle", {11'd0, dec_valid, fwd_down, fwd_up, pf_ok, single_xfer}, 16'd0);

      // R5 / R6 enables
      mem_en = 1'b0;
      txn(1'b0, 1'b0, 4'h6, 32'h1000_0000, 4'b0000, "R5 mem_en off");
      mem_en = 1'b1;
      master_en = 1'b0;
      txn(1'b1, 1'b0, 4'h6, 32'h8000_0000, 4'b0000, "R6 master_en off");
      master_en = 1'b1;

      // R4 disable and single-block window
      cfg_write(8'h20, 16'h2000, 2'b11);
      txn(1'b0, 1'b0, 4'h6, 32'h1000_0000, 4'b0000, "R4 disabled window no down");
      txn(1'b1, 1'b0, 4'h6, 32'h1000_0000, 4'b0101, "R4 disabled window goes up");
      cfg_write(8'h20, 16'h1FF0, 2'b11);
      txn(1'b0, 1'b0, 4'h6, 32'h1FF0_0000, 4'b1001, "R4 base equals limit hit");
      txn(1'b0, 1'b0, 4'h6, 32'h1FEF_FFFC, 4'b0000, "R4 base equals limit below");

      // R3 full 4GB prefetch window
      cfg_write(8'h24, 16'h0000, 2'b11);
      cfg_write(8'h26, 16'hFFF0, 2'b11);
      txn(1'b0, 1'b0, 4'h6, 32'hFFFF_FFFC, 4'b1010, "R3 full range top");
      txn(1'b1, 1'b0, 4'h7, 32'hFFFF_FFFC, 4'b0000, "R3 full range secondary ignored");

      @(negedge clk);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule